// File: doc/BRIEF.md
# Parity Error Control/Status Register

This block holds the 8-bit control/status register of a byte-parity memory slave and decides how each memory cycle ends. On every valid read cycle the data path hands over one mismatch flag per byte lane. A mismatch on any lane sets a sticky error-detect bit. That bit drives the error LED directly and stays set until software writes the register or the block is reset.

A trap-enable bit in the same register chooses the outcome of a read that shows a parity error. With trapping on, the cycle ends in a bus-error response. With trapping off, every valid cycle ends in a normal acknowledge. The trap-enable bit takes its value from a configuration strap at reset, and software can change it afterwards. Two spare bits can be read and written. The upper nibble always reads as zero.

Top module: `parity_err_csr`

## Requirements
- R1: While reset is high and on the first cycle after it, the error bit (D0) and the spare bits (D1, D3) read 0, the trap-enable bit (D2) equals `cfg_trap_en_i`, and the error, LED, acknowledge and bus-error outputs are 0.
- R2: A valid read cycle (`cyc_valid_i`=1, `cyc_read_i`=1) with any bit of `lane_err_i` set makes D0 equal 1 after the next clock edge, whichever lane it is. D0 then stays 1 until a register write or a reset.
- R3: `lane_err_i` has no effect on D0 during a valid write cycle (`cyc_read_i`=0) or when `cyc_valid_i`=0.
- R4: A register write (`reg_wr_i`=1) clears D0 whatever the value of write-data bit 0. The same write loads D1, D2 and D3 from write-data bits 1, 2 and 3.
- R5: When a parity error and a register write fall in the same cycle, D0 is 1 after the edge.
- R6: A valid read with a parity error while D2=1 yields `term_berr_o`=1 for one cycle, one cycle later. The D2 value that counts is the one held before any write in that same cycle. In every other valid cycle the outcome is `term_ack_o`.
- R7: Each valid cycle produces exactly one termination pulse (acknowledge or bus error) in the following cycle. Neither termination output is high in a cycle that follows a cycle with `cyc_valid_i`=0.
- R8: `reg_rd_i`=1 loads `reg_rdata_o` at the next edge with the register contents as they stood before any same-cycle update. Bits 7..4 are 0. Otherwise `reg_rdata_o` holds its value.
- R9: `err_led_o` and `err_flag_o` equal D0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_trap_en_i | input | 1 | Reset value of the trap-enable bit |
| cyc_valid_i | input | 1 | A memory cycle completes in this clock |
| cyc_read_i | input | 1 | The completing cycle is a read |
| lane_err_i | input | 4 | Per-byte-lane parity mismatch flags |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, byte lane 7..0 |
| err_flag_o | output | 1 | Sticky parity error bit D0 |
| err_led_o | output | 1 | Error LED drive, follows D0 |
| term_ack_o | output | 1 | Normal acknowledge for the previous cycle |
| term_berr_o | output | 1 | Bus-error termination for the previous cycle |

## Verification
The assertions assume that the memory-cycle strobe lasts exactly one clock per completed cycle. They also assume that `lane_err_i` is meaningful only while that strobe is high, and that a read is held in `cyc_read_i` during the same clock. The bench drives each cycle and each register access as a single-clock pulse on the falling edge and then returns every strobe to 0. This matches that model. The bench also places lane errors on write cycles and idle cycles on purpose, to show that they are ignored.

// File: rtl/parity_err_csr_pkg.sv
package parity_err_csr_pkg;
  localparam int unsigned LANES   = 4;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned IMPL_W  = 4;
  localparam int unsigned BIT_ERR   = 0;
  localparam int unsigned BIT_SPARE0 = 1;
  localparam int unsigned BIT_TRAP  = 2;
  localparam int unsigned BIT_SPARE1 = 3;

  typedef enum logic [1:0] {
    TERM_NONE = 2'b00,
    TERM_ACK  = 2'b01,
    TERM_BERR = 2'b10
  } term_e;
endpackage

// File: rtl/pec_lane_check.sv
module pec_lane_check #(
  parameter int unsigned LANES = 4
) (
  input  logic             cyc_valid_i,
  input  logic             cyc_read_i,
  input  logic [LANES-1:0] lane_err_i,
  output logic             par_err_o
);
  logic             rd_qual;
  logic [LANES-1:0] lane_hit;

  assign rd_qual = cyc_valid_i & cyc_read_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = rd_qual & lane_err_i[g];
  end

  assign par_err_o = |lane_hit;
endmodule

// File: rtl/pec_reg_bits.sv
module pec_reg_bits
  import parity_err_csr_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned IW = IMPL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_trap_en_i,
  input  logic          par_err_i,
  input  logic          wr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic          rd_i,
  output logic          err_o,
  output logic          trap_o,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = W - IW;

  logic          err_q;
  logic          trap_q;
  logic          spare0_q;
  logic          spare1_q;
  logic [IW-1:0] image;

  always_comb begin
    image             = '0;
    image[BIT_ERR]    = err_q;
    image[BIT_SPARE0] = spare0_q;
    image[BIT_TRAP]   = trap_q;
    image[BIT_SPARE1] = spare1_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= 1'b0;
      trap_q   <= cfg_trap_en_i;
      spare0_q <= 1'b0;
      spare1_q <= 1'b0;
    end else begin
      if (wr_i) begin
        trap_q   <= wdata_i[BIT_TRAP];
        spare0_q <= wdata_i[BIT_SPARE0];
        spare1_q <= wdata_i[BIT_SPARE1];
      end
      if (par_err_i)  err_q <= 1'b1;
      else if (wr_i)  err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= {{PAD_W{1'b0}}, image};
  end

  assign err_o  = err_q;
  assign trap_o = trap_q;

  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    par_err_i |=> err_q);
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !wr_i) |=> err_q);
  // R4
  err_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !par_err_i) |=> !err_q);
  // R5
  err_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && par_err_i) |=> err_q);
  // R4
  trap_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (trap_q == $past(wdata_i[BIT_TRAP])));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/pec_term.sv
module pec_term
  import parity_err_csr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_valid_i,
  input  logic par_err_i,
  input  logic trap_i,
  output logic ack_o,
  output logic berr_o
);
  term_e nxt, cur;

  always_comb begin
    if (!cyc_valid_i)             nxt = TERM_NONE;
    else if (par_err_i && trap_i) nxt = TERM_BERR;
    else                          nxt = TERM_ACK;
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= TERM_NONE;
    else     cur <= nxt;
  end

  assign ack_o  = (cur == TERM_ACK);
  assign berr_o = (cur == TERM_BERR);

  // R7
  term_one_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_valid_i |=> $countones({ack_o, berr_o}) == 1);
  // R7
  term_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid_i |=> !ack_o && !berr_o);
  // R6
  term_notrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid_i && !trap_i) |=> ack_o);
endmodule

// File: rtl/parity_err_csr.sv
module parity_err_csr
  import parity_err_csr_pkg::*;
#(
  parameter int unsigned NUM_LANES = LANES,
  parameter int unsigned DATA_W    = REG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_trap_en_i,
  input  logic                 cyc_valid_i,
  input  logic                 cyc_read_i,
  input  logic [NUM_LANES-1:0] lane_err_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 err_flag_o,
  output logic                 err_led_o,
  output logic                 term_ack_o,
  output logic                 term_berr_o
);
  logic par_err;
  logic err_bit;
  logic trap_bit;

  pec_lane_check #(.LANES(NUM_LANES)) u_lanes (
    .cyc_valid_i (cyc_valid_i),
    .cyc_read_i  (cyc_read_i),
    .lane_err_i  (lane_err_i),
    .par_err_o   (par_err)
  );

  pec_reg_bits #(.W(DATA_W), .IW(IMPL_W)) u_bits (
    .clk           (clk),
    .rst           (rst),
    .cfg_trap_en_i (cfg_trap_en_i),
    .par_err_i     (par_err),
    .wr_i          (reg_wr_i),
    .wdata_i       (reg_wdata_i[IMPL_W-1:0]),
    .rd_i          (reg_rd_i),
    .err_o         (err_bit),
    .trap_o        (trap_bit),
    .rdata_o       (reg_rdata_o)
  );

  pec_term u_term (
    .clk         (clk),
    .rst         (rst),
    .cyc_valid_i (cyc_valid_i),
    .par_err_i   (par_err),
    .trap_i      (trap_bit),
    .ack_o       (term_ack_o),
    .berr_o      (term_berr_o)
  );

  assign err_flag_o = err_bit;
  assign err_led_o  = err_bit;

  // R3
  no_err_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid_i && !cyc_read_i && !err_flag_o) |=> !err_flag_o);
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> reg_rdata_o[DATA_W-1:IMPL_W] == '0);
  // R6
  berr_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid_i && !cyc_read_i) |=> term_ack_o);
endmodule

// File: tb/test_parity_err_csr.sv
module test_parity_err_csr;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_trap_en = 1'b0;
  logic       cyc_valid = 1'b0;
  logic       cyc_read = 1'b0;
  logic [3:0] lane_err = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       err_flag, err_led, term_ack, term_berr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  parity_err_csr i_parity_err_csr (
    .clk(clk), .rst(rst), .cfg_trap_en_i(cfg_trap_en),
    .cyc_valid_i(cyc_valid), .cyc_read_i(cyc_read), .lane_err_i(lane_err),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .err_flag_o(err_flag), .err_led_o(err_led),
    .term_ack_o(term_ack), .term_berr_o(term_berr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic cfg);
    @(negedge clk);
    cfg_trap_en = cfg; rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // one memory cycle; outputs sampled at the following negedge
  task automatic mem_cycle(logic rd, logic [3:0] lanes,
                           output logic ack, output logic berr);
    cyc_valid = 1'b1; cyc_read = rd; lane_err = lanes;
    @(negedge clk);
    cyc_valid = 1'b0; cyc_read = 1'b0; lane_err = '0;
    ack = term_ack; berr = term_berr;
  endtask

  task automatic wr_reg(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(output logic [7:0] d);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    do_reset(1'b1);
    check("R1 flag", {7'b0, err_flag}, 8'h0);
    check("R1 term", {6'b0, term_ack, term_berr}, 8'h0);
    rd_reg(d);
    check("R1 reg cfg=1", d, 8'h04);
    do_reset(1'b0);
    rd_reg(d);
    check("R1 reg cfg=0", d, 8'h00);
  endtask

  task automatic t_lanes_notrap;
    logic a, b;
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin
      do_reset(1'b0);
      mem_cycle(1'b1, 4'b0001 << i, a, b);
      check("R2 lane flag", {7'b0, err_flag}, 8'h1);
      check("R9 led", {7'b0, err_led}, 8'h1);
      check("R6 ack untrapped", {6'b0, a, b}, 8'h2);
    end
    repeat (5) @(negedge clk);
    mem_cycle(1'b1, 4'b0000, a, b);
    check("R2 sticky", {7'b0, err_flag}, 8'h1);
    rd_reg(d);
    check("R8 read err", d, 8'h01);
  endtask

  task automatic t_trap;
    logic a, b;
    do_reset(1'b1);
    mem_cycle(1'b1, 4'b0000, a, b);
    check("R6 clean read ack", {6'b0, a, b}, 8'h2);
    mem_cycle(1'b1, 4'b1010, a, b);
    check("R6 berr", {6'b0, a, b}, 8'h1);
    @(negedge clk);
    check("R7 single pulse", {6'b0, term_ack, term_berr}, 8'h0);
    // write turning trap off in the same cycle as an erroring read
    reg_wr = 1'b1; reg_wdata = 8'h00;
    mem_cycle(1'b1, 4'b0100, a, b);
    reg_wr = 1'b0;
    check("R6 old trap used", {6'b0, a, b}, 8'h1);
    check("R5 error wins", {7'b0, err_flag}, 8'h1);
    mem_cycle(1'b1, 4'b0100, a, b);
    check("R6 trap now off", {6'b0, a, b}, 8'h2);
  endtask

  task automatic t_ignore;
    logic a, b;
    do_reset(1'b1);
    mem_cycle(1'b0, 4'b1111, a, b);
    check("R3 write cycle flag", {7'b0, err_flag}, 8'h0);
    check("R3 write cycle ack", {6'b0, a, b}, 8'h2);
    lane_err = 4'b1111; cyc_read = 1'b1;
    @(negedge clk);
    lane_err = '0; cyc_read = 1'b0;
    check("R3 idle flag", {7'b0, err_flag}, 8'h0);
    check("R7 idle term", {6'b0, term_ack, term_berr}, 8'h0);
  endtask

  task automatic t_write;
    logic a, b;
    logic [7:0] d;
    do_reset(1'b0);
    mem_cycle(1'b1, 4'b0010, a, b);
    wr_reg(8'hFF);
    check("R4 clear on write d0=1", {7'b0, err_flag}, 8'h0);
    check("R9 led off", {7'b0, err_led}, 8'h0);
    rd_reg(d);
    check("R8 upper zero", d, 8'h0E);
    wr_reg(8'h0A);
    rd_reg(d);
    check("R4 spares", d, 8'h0A);
    // read in same cycle as error: old contents returned
    reg_rd = 1'b1;
    mem_cycle(1'b1, 4'b0001, a, b);
    reg_rd = 1'b0;
    check("R8 pre-update", reg_rdata, 8'h0A);
    repeat (3) @(negedge clk);
    check("R8 hold", reg_rdata, 8'h0A);
    rd_reg(d);
    check("R8 new", d, 8'h0B);
  endtask

  initial begin
    t_reset();
    t_lanes_notrap();
    t_trap();
    t_ignore();
    t_write();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule